// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper

This block regulates the current in one full bridge by chopping it. It counts in ticks of an internal oscillator, delivered as a one-cycle strobe. While the bridge is driven, the block first waits out a programmable blanking interval and then watches a digital current-trip input. A trip starts a fixed off-time. Depending on configuration, the off-time recirculates entirely in slow decay, or it opens with a programmable stretch of fast decay and finishes in slow decay. When the bridge has to be turned off from outside, a low enable input chops it with a decay choice of its own. A change of the phase input reverses the drive direction and forces a fresh off cycle.

The outputs are four gate enables, one high-side and one low-side for each leg of the bridge. A fixed dead-time, counted in clock cycles, separates turning a switch off from turning any new switch on. A chip instantiates one copy per bridge. The comparator, the reference DAC and the current-zero sensing lie outside the block. Only the all-zero DAC code is seen here, and it disables the bridge.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: After reset all four gate enables are low, and the block stays idle until it sees a nonzero DAC code.
- R2: While driving, phase 1 turns on hiA and loB, and phase 0 turns on hiB and loA (gate vector {hiA,loA,hiB,loB} = 1001 and 0110).
- R3: Each drive period begins with blanking. blankCode 0, 1, 2 and 3 gives 4, 6, 12 and 24 oscillator ticks, and the trip input has no effect during blanking.
- R4: After blanking, a high trip input on any clock cycle ends the drive and starts the off-time on the next cycle.
- R5: The off-time lasts ((1+offCode)×8 − 1) oscillator ticks (offCode 0..31), then drive resumes with a new blanking interval.
- R6: With intSlow=0 the off-time runs fast decay (the switches opposite the drive, phase 1 gives 0110) for ((1+fastCode)×8 − 1) ticks (fastCode 0..15), then slow decay (loA and loB, 0101). If that fast portion is at least as long as the off-time, the whole off-time is fast. With intSlow=1 the whole off-time is slow.
- R7: enable low chops the bridge at once, in fast decay when extSlow=0 and in slow decay when extSlow=1. When enable returns high, drive restarts with blanking.
- R8: A change of the phase input starts a full off-time and clears any running blanking. The block then drives in the new direction.
- R9: dacCode 0000 forces all gate enables low from the next cycle. This has priority over every other input.
- R10: hiX and loX of one leg are never both high. When the gate pattern changes, switches to be turned off go low at once, and switches to be turned on rise DEAD_CLKS clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle strobe per oscillator period |
| offCode | input | 5 | Off-time code N |
| fastCode | input | 4 | Fast-decay portion code N |
| blankCode | input | 2 | Blanking length select |
| intSlow | input | 1 | Off-time decay: 0 mixed, 1 slow |
| extSlow | input | 1 | Enable-chop decay: 0 fast, 1 slow |
| dacCode | input | 4 | Current setting; only zero is decoded (bridge disabled) |
| phase | input | 1 | Drive direction |
| enable | input | 1 | Low chops the bridge |
| trip | input | 1 | Digital current-trip from the sense comparator |
| hiA | output | 1 | Leg A high-side gate enable |
| loA | output | 1 | Leg A low-side gate enable |
| hiB | output | 1 | Leg B high-side gate enable |
| loB | output | 1 | Leg B low-side gate enable |

## Verification
The bench builds the block with its default parameters: 5-bit off code, 4-bit fast code, ×8 tick law, 4-tick minimum blank and 3 clocks of dead-time. Oscillator ticks arrive every third clock. With these values every off-time code, including the longest (255 ticks), all four blanking lengths and the fast-longer-than-off case fit within a short run. The three-clock dead-time is long enough that a new pattern arriving while the dead-time counts exercises the restart of the dead-time wait.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_SENSE,
    ST_OFF,
    ST_CHOP
  } chopState_t;

  typedef enum logic [1:0] {
    PAT_NONE,
    PAT_DRIVE,
    PAT_FAST,
    PAT_SLOW
  } gatePat_t;

  typedef struct packed {
    logic loadBlank;
    logic loadOff;
    logic countTick;
  } chopStrobe_t;

endpackage

// File: rtl/chop_timer.sv
module chop_timer
  import chop_pkg::*;
#(
  parameter int OFF_BITS  = 5,
  parameter int FAST_BITS = 4,
  parameter int TICK_MULT = 8,
  parameter int BLANK_MIN = 4,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chopStrobe_t          strobe,
  input  logic [OFF_BITS-1:0]  offCode,
  input  logic [FAST_BITS-1:0] fastCode,
  input  logic [1:0]           blankCode,
  output logic                 cntAtOne,
  output logic                 fastActive
);

  logic [CNT_W-1:0] mainCnt;
  logic [CNT_W-1:0] fastCnt;
  logic [CNT_W-1:0] offLen;
  logic [CNT_W-1:0] fastLen;
  logic [CNT_W-1:0] blankLen;

  // (1+N) periods of TICK_MULT ticks, minus one tick
  always_comb begin
    offLen  = CNT_W'((int'(offCode) + 1) * TICK_MULT - 1);
    fastLen = CNT_W'((int'(fastCode) + 1) * TICK_MULT - 1);
    unique case (blankCode)
      2'd0:    blankLen = CNT_W'(BLANK_MIN);
      2'd1:    blankLen = CNT_W'((BLANK_MIN * 3) / 2);
      2'd2:    blankLen = CNT_W'(BLANK_MIN * 3);
      default: blankLen = CNT_W'(BLANK_MIN * 6);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCnt <= '0;
      fastCnt <= '0;
    end else begin
      if (strobe.loadBlank)
        mainCnt <= blankLen;
      else if (strobe.loadOff)
        mainCnt <= offLen;
      else if (strobe.countTick && mainCnt != '0)
        mainCnt <= mainCnt - 1'b1;

      if (strobe.loadOff)
        fastCnt <= fastLen;
      else if (strobe.loadBlank)
        fastCnt <= '0;
      else if (strobe.countTick && fastCnt != '0)
        fastCnt <= fastCnt - 1'b1;
    end
  end

  assign cntAtOne   = (mainCnt == CNT_W'(1));
  assign fastActive = (fastCnt != '0);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int DAC_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                oscTick,
  input  logic                trip,
  input  logic                enable,
  input  logic                phase,
  input  logic                intSlow,
  input  logic                extSlow,
  input  logic [DAC_BITS-1:0] dacCode,
  input  logic                cntAtOne,
  input  logic                fastActive,
  output chopStrobe_t         strobe,
  output gatePat_t            pattern,
  output logic                phaseQ
);

  chopState_t state;
  chopState_t nextState;
  logic       dacOff;
  logic       phaseFlip;

  assign dacOff    = (dacCode == '0);
  assign phaseFlip = (phase != phaseQ);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (dacOff) begin
      nextState = ST_IDLE;
    end else if (phaseFlip) begin
      nextState      = ST_OFF;
      strobe.loadOff = 1'b1;
    end else if (!enable) begin
      nextState = ST_CHOP;
    end else begin
      unique case (state)
        ST_IDLE, ST_CHOP: begin
          nextState        = ST_BLANK;
          strobe.loadBlank = 1'b1;
        end
        ST_BLANK: begin
          strobe.countTick = oscTick;
          if (oscTick && cntAtOne) nextState = ST_SENSE;
        end
        ST_SENSE: begin
          if (trip) begin
            nextState      = ST_OFF;
            strobe.loadOff = 1'b1;
          end
        end
        ST_OFF: begin
          strobe.countTick = oscTick;
          if (oscTick && cntAtOne) begin
            nextState        = ST_BLANK;
            strobe.loadBlank = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phaseQ <= 1'b0;
    end else begin
      state  <= nextState;
      phaseQ <= phase;
    end
  end

  always_comb begin
    unique case (state)
      ST_BLANK, ST_SENSE: pattern = PAT_DRIVE;
      ST_OFF:             pattern = (!intSlow && fastActive) ? PAT_FAST : PAT_SLOW;
      ST_CHOP:            pattern = extSlow ? PAT_SLOW : PAT_FAST;
      default:            pattern = PAT_NONE;
    endcase
  end

  // R9: zero DAC code idles the bridge
  a_r9_dac_idle: assert property (@(posedge clk) disable iff (!rstN)
    (dacCode == '0) |=> (state == ST_IDLE));

  // R3: sensing is reached only through blanking
  a_r3_sense_after_blank: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SENSE) |-> ($past(state) == ST_BLANK || $past(state) == ST_SENSE));

  // R4: leaving sense for the off-time needs a trip or a phase flip
  a_r4_off_needs_trip: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && $past(state) == ST_SENSE) |-> ($past(trip) || $past(phase) != $past(phaseQ)));

  // R7: low enable chops on the next cycle
  a_r7_enable_chop: assert property (@(posedge clk) disable iff (!rstN)
    (dacCode != '0 && !enable && phase == phaseQ) |=> (state == ST_CHOP));

endmodule

// File: rtl/chop_gates.sv
module chop_gates
  import chop_pkg::*;
#(
  parameter int DEAD_CLKS = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  gatePat_t pattern,
  input  logic     phaseQ,
  output logic [3:0] gates
);

  // gate vector order: {hiA, loA, hiB, loB}
  logic [3:0] target;

  always_comb begin
    unique case (pattern)
      PAT_DRIVE: target = phaseQ ? 4'b1001 : 4'b0110;
      PAT_FAST:  target = phaseQ ? 4'b0110 : 4'b1001;
      PAT_SLOW:  target = 4'b0101;
      default:   target = 4'b0000;
    endcase
  end

  generate
    if (DEAD_CLKS == 0) begin : gNoDead
      always_ff @(posedge clk) begin
        if (!rstN) gates <= '0;
        else       gates <= target;
      end
    end else begin : gDead
      localparam int DW = $clog2(DEAD_CLKS + 1);
      logic [3:0]    goalQ;
      logic [DW-1:0] deadCnt;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          gates   <= '0;
          goalQ   <= '0;
          deadCnt <= '0;
        end else if (target != goalQ) begin
          goalQ   <= target;
          gates   <= gates & target;
          deadCnt <= DW'(DEAD_CLKS);
        end else if (deadCnt != '0) begin
          deadCnt <= deadCnt - 1'b1;
          if (deadCnt == DW'(1)) gates <= goalQ;
        end
      end

      // R10: complementary switch was already off one cycle before a turn-on
      a_r10_gap_hia: assert property (@(posedge clk) disable iff (!rstN)
        $rose(gates[3]) |-> !$past(gates[2]));
      a_r10_gap_lob: assert property (@(posedge clk) disable iff (!rstN)
        $rose(gates[0]) |-> !$past(gates[1]));
    end
  endgenerate

  // R10: no leg ever conducts straight through
  a_r10_leg_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(gates[3] && gates[2]) && !(gates[1] && gates[0]));

endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_BITS  = 5,
  parameter int FAST_BITS = 4,
  parameter int DAC_BITS  = 4,
  parameter int TICK_MULT = 8,
  parameter int BLANK_MIN = 4,
  parameter int DEAD_CLKS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oscTick,
  input  logic [OFF_BITS-1:0]  offCode,
  input  logic [FAST_BITS-1:0] fastCode,
  input  logic [1:0]           blankCode,
  input  logic                 intSlow,
  input  logic                 extSlow,
  input  logic [DAC_BITS-1:0]  dacCode,
  input  logic                 phase,
  input  logic                 enable,
  input  logic                 trip,
  output logic                 hiA,
  output logic                 loA,
  output logic                 hiB,
  output logic                 loB
);

  localparam int OFF_MAX  = (1 << OFF_BITS) * TICK_MULT;
  localparam int BLK_MAX  = BLANK_MIN * 6 + 1;
  localparam int CNT_W    = $clog2(OFF_MAX > BLK_MAX ? OFF_MAX : BLK_MAX);

  chopStrobe_t strobe;
  gatePat_t    pattern;
  logic        phaseQ;
  logic        cntAtOne;
  logic        fastActive;
  logic [3:0]  gates;

  chop_ctrl #(.DAC_BITS(DAC_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .trip(trip), .enable(enable),
    .phase(phase), .intSlow(intSlow), .extSlow(extSlow), .dacCode(dacCode),
    .cntAtOne(cntAtOne), .fastActive(fastActive), .strobe(strobe),
    .pattern(pattern), .phaseQ(phaseQ)
  );

  chop_timer #(
    .OFF_BITS(OFF_BITS), .FAST_BITS(FAST_BITS), .TICK_MULT(TICK_MULT),
    .BLANK_MIN(BLANK_MIN), .CNT_W(CNT_W)
  ) uTimer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .offCode(offCode),
    .fastCode(fastCode), .blankCode(blankCode), .cntAtOne(cntAtOne),
    .fastActive(fastActive)
  );

  chop_gates #(.DEAD_CLKS(DEAD_CLKS)) uGates (
    .clk(clk), .rstN(rstN), .pattern(pattern), .phaseQ(phaseQ), .gates(gates)
  );

  assign {hiA, loA, hiB, loB} = gates;

endmodule

// File: tb/chop_bridge_ctrl_test.sv
module chop_bridge_ctrl_test;

  localparam int DEAD = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b0;
  logic [4:0] offCode = '0;
  logic [3:0] fastCode = '0;
  logic [1:0] blankCode = '0;
  logic       intSlow = 1'b0;
  logic       extSlow = 1'b0;
  logic [3:0] dacCode = '0;
  logic       phase = 1'b0;
  logic       enable = 1'b1;
  logic       trip = 1'b0;
  logic       hiA, loA, hiB, loB;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tickDiv = 0;
  int tripMode = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chop_bridge_ctrl uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .offCode(offCode),
    .fastCode(fastCode), .blankCode(blankCode), .intSlow(intSlow),
    .extSlow(extSlow), .dacCode(dacCode), .phase(phase), .enable(enable),
    .trip(trip), .hiA(hiA), .loA(loA), .hiB(hiB), .loB(loB)
  );

  // reference model: 0 idle, 1 blank, 2 sense, 3 off, 4 chop
  int mState = 0, mRem = 0, mFast = 0, mDead = 0;
  bit mPhase = 0, mViaPhase = 0;
  logic [3:0] mGate = '0, mGoal = '0;

  function automatic int blankTicks(input logic [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 6;
      2'd2: return 12;
      default: return 24;
    endcase
  endfunction

  function automatic logic [3:0] wantPattern();
    case (mState)
      1, 2: return mPhase ? 4'b1001 : 4'b0110;           // R2
      3: return (!intSlow && mFast > 0) ? (mPhase ? 4'b0110 : 4'b1001) : 4'b0101; // R6
      4: return extSlow ? 4'b0101 : (mPhase ? 4'b0110 : 4'b1001);   // R7
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string tagNow();
    case (mState)
      0: return (dacCode == 0) ? "R9" : "R1";
      1: return "R3";
      2: return "R4";
      3: return mViaPhase ? "R8" : ((mFast > 0) ? "R6" : "R5");
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mRem = 0; mFast = 0; mDead = 0; mPhase = 0;
      mGate = '0; mGoal = '0; mViaPhase = 0;
    end else begin
      logic [3:0] tgt;
      tgt = wantPattern();
      if (tgt != mGoal) begin
        mGoal = tgt; mGate = mGate & tgt; mDead = DEAD;
      end else if (mDead > 0) begin
        if (mDead == 1) mGate = mGoal;
        mDead--;
      end
      if (dacCode == 0) mState = 0;
      else if (phase != mPhase) begin
        mState = 3; mRem = (offCode + 1) * 8 - 1; mFast = (fastCode + 1) * 8 - 1; mViaPhase = 1;
      end else if (!enable) mState = 4;
      else begin
        case (mState)
          0, 4: begin mState = 1; mRem = blankTicks(blankCode); mFast = 0; end
          1: if (oscTick) begin if (mRem == 1) mState = 2; mRem--; end
          2: if (trip) begin
               mState = 3; mRem = (offCode + 1) * 8 - 1; mFast = (fastCode + 1) * 8 - 1; mViaPhase = 0;
             end
          3: if (oscTick) begin
               if (mFast > 0) mFast--;
               if (mRem == 1) begin mState = 1; mRem = blankTicks(blankCode); mFast = 0; end
               else mRem--;
             end
          default: mState = 0;
        endcase
      end
      mPhase = phase;
    end
  end

  // stimulus helpers on the falling edge: tick every third clock, trip pattern
  always @(negedge clk) begin
    cyc++;
    tickDiv = (tickDiv + 1) % 3;
    oscTick <= (tickDiv == 0);
    case (tripMode)
      1: trip <= 1'b1;
      2: trip <= (cyc % 37 == 0);
      default: trip <= 1'b0;
    endcase
    if (rstN && !done) begin
      checks++;
      if ({hiA, loA, hiB, loB} !== mGate) begin
        errors++;
        $display("FAIL %s cycle %0d: gates=%b expected=%b", tagNow(), cyc, {hiA, loA, hiB, loB}, mGate);
      end
      checks++;
      if ((hiA && loA) || (hiB && loB)) begin
        errors++;
        $display("FAIL R10 cycle %0d: gates=%b expected no leg shorted", cyc, {hiA, loA, hiB, loB});
      end
    end
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    // R1: reset state
    checks++;
    if ({hiA, loA, hiB, loB} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: gates=%b expected=0000", {hiA, loA, hiB, loB});
    end
    rstN = 1'b1;
    run(20);   // R1, R9: dac zero keeps idle
    // R2, R3, R4, R5, R6: shortest off, fast portion equals off-time
    dacCode = 4'd8; phase = 1'b1; tripMode = 1;
    run(600);
    // R6: mixed with slow tail
    offCode = 5'd3; fastCode = 4'd1; blankCode = 2'd1; tripMode = 2;
    run(1500);
    // R6: fast portion longer than off-time
    offCode = 5'd0; fastCode = 4'd3; blankCode = 2'd2; tripMode = 1;
    run(800);
    // R6: internal slow only
    intSlow = 1'b1; offCode = 5'd2; blankCode = 2'd3;
    run(1200);
    // R3: trip held during every blank, codes swept
    intSlow = 1'b0;
    for (int b = 0; b < 4; b++) begin
      blankCode = 2'(b);
      run(500);
    end
    // R8: phase flips in several states
    phase = 1'b0; run(7);
    phase = 1'b1; run(400);
    phase = 1'b0; run(900);
    // R7: enable chop, fast then slow decay
    tripMode = 2;
    enable = 1'b0; extSlow = 1'b0; run(60);
    enable = 1'b1; run(150);
    enable = 1'b0; extSlow = 1'b1; run(60);
    enable = 1'b1; run(2);
    enable = 1'b0; run(2);
    enable = 1'b1; run(300);
    // R10: rapid pattern changes inside dead-time
    enable = 1'b0; run(1); extSlow = 1'b0; run(1); enable = 1'b1; run(1);
    phase = 1'b1; run(2); phase = 1'b0; run(200);
    // R5: longest off-time
    offCode = 5'd31; fastCode = 4'd15; tripMode = 1;
    run(2500);
    // R9: dac zero mid-off and recovery
    dacCode = 4'd0; run(40);
    dacCode = 4'd1; run(400);
    // R9: dac zero while driving
    tripMode = 0; run(200);
    dacCode = 4'd0; run(30);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule